// File: doc/BRIEF.md
# Flash status and write-protect controller

This block keeps the status byte of a serial flash memory and decides whether each write-class command may change the array or the status. The serial front end hands it decoded events: a command event carries the opcode and the target address, a byte event carries one data byte, and an end event marks the point where chip select returns high. A write-protect pin qualifies the lock-down bit. The block keeps the busy flag, the write-enable latch, two protection-level bits, the top/bottom selector and the lock-down bit. It compares target addresses against the protected range and runs a busy timer that stands in for the time the array takes.

An accepted program, erase or status write raises an accept strobe for one cycle. The strobe carries the operation kind and an aligned address for the array controller. A refused one raises a reject strobe instead. During page programming each permitted data byte is forwarded with its array address. That address wraps inside the 256-byte page. The protection bits are non-volatile in the real memory. Here they are registers that load a reset value from an input.

Top module: `flash_wp_ctrl`

## Requirements
- R1: The status byte holds BUSY in bit 0, the write-enable latch (WEL) in bit 1, BP0 in bit 2, BP1 in bit 3, TB in bit 5 and the lock bit BPL in bit 7. Bits 4 and 6 read 0. Reset clears BUSY and WEL and loads `nv_prot_i` = {BPL, TB, BP1, BP0} into the protection bits.
- R2: An end event for opcode 06h sets WEL. An end event for opcode 04h clears it.
- R3: Program (02h), sector erase (20h or D7h), block erase (D8h), chip erase (60h or C7h) and status write (01h) have no effect while WEL is 0. There is no strobe, no forwarded byte and no status change.
- R4: Every write-class command that completes with WEL set clears WEL, whether it is accepted or rejected.
- R5: A status write (01h with at least one data byte) is refused when `wp_n_i` is 0 and BPL is 1. Otherwise bits 7, 5, 3 and 2 of its first data byte are copied into the status.
- R6: The protected range follows {BP1,BP0}. With 00 nothing is protected and with 11 the whole range 00000h–3FFFFh is protected. With TB=0, 01 protects 30000h–3FFFFh and 10 protects 20000h–3FFFFh. With TB=1, 01 protects 00000h–0FFFFh and 10 protects 00000h–1FFFFh.
- R7: A program or erase whose target lies in the protected range raises `rej_o` for one cycle and never `acc_o`. Otherwise `acc_o` pulses in the cycle after the end event. The two strobes never pulse together.
- R8: On accept, `op_kind_o` is 1 for program, 2 for sector erase, 3 for block erase, 4 for chip erase and 5 for status write. `op_addr_o` is the program start address, the address with bits 11–0 cleared for a sector erase, the address with bits 15–0 cleared for a block erase, and 0 for chip erase and status write.
- R9: Chip erase is accepted only when BP0, BP1 and TB are all 0. Otherwise it is rejected.
- R10: An accept loads the busy timer with that operation's cycle input. BUSY then reads 1 for exactly that many cycles, beginning in the cycle of the strobe. A count of 0 leaves BUSY at 0.
- R11: A command event that arrives while BUSY is 1 is ignored, together with its bytes and its end event.
- R12: During a permitted program, each data byte is forwarded one cycle later on `prog_wr_o`, `prog_addr_o` and `prog_data_o`. The first address is the start address. Each later address adds 1 to the low 8 bits and keeps the page bits, so the address wraps to the start of the same 256-byte page. No byte is forwarded when the program is not permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_prot_i | input | 4 | Reset value {BPL, TB, BP1, BP0} |
| wp_n_i | input | 1 | Write-protect pin, active low |
| ev_cmd_i | input | 1 | Command event (opcode and address are valid) |
| cmd_op_i | input | 8 | Opcode |
| cmd_addr_i | input | ADDR_W | Target address |
| ev_byte_i | input | 1 | Data byte event |
| byte_i | input | 8 | Data byte |
| ev_end_i | input | 1 | Command end event (select released) |
| t_prog_i | input | TMR_W | Busy cycles for program |
| t_sect_i | input | TMR_W | Busy cycles for sector erase |
| t_blk_i | input | TMR_W | Busy cycles for block erase |
| t_chip_i | input | TMR_W | Busy cycles for chip erase |
| t_wrsr_i | input | TMR_W | Busy cycles for status write |
| status_o | output | 8 | Status byte |
| acc_o | output | 1 | Operation accepted strobe |
| rej_o | output | 1 | Operation rejected strobe |
| op_kind_o | output | 3 | Kind of the accepted or rejected operation |
| op_addr_o | output | ADDR_W | Aligned target address |
| prog_wr_o | output | 1 | Program byte strobe |
| prog_addr_o | output | ADDR_W | Program byte address |
| prog_data_o | output | 8 | Program byte data |

## Verification
The assertions assume that the front end raises at most one of the three event inputs in any cycle. They also assume that every command event is eventually followed by an end event. This is what lets them tie each strobe to the WEL, BUSY and protection state of the cycle before it. The stimulus tasks drive one event per cycle and always close a command with an end event. This holds even when a command is issued while BUSY is 1 or a write is expected to be refused. The pin and the timer inputs change only while no command is open.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_SE_A = 8'h20;
  localparam logic [7:0] OP_SE_B = 8'hD7;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE_A = 8'h60;
  localparam logic [7:0] OP_CE_B = 8'hC7;

  typedef enum logic [2:0] {
    OPK_NONE = 3'd0,
    OPK_PROG = 3'd1,
    OPK_SECT = 3'd2,
    OPK_BLK  = 3'd3,
    OPK_CHIP = 3'd4,
    OPK_WRSR = 3'd5
  } op_kind_t;

  typedef struct packed {
    logic bpl;
    logic tb;
    logic bp1;
    logic bp0;
  } prot_t;

  function automatic op_kind_t op_class(input logic [7:0] op);
    op_kind_t k;
    case (op)
      OP_PROG:          k = OPK_PROG;
      OP_SE_A, OP_SE_B: k = OPK_SECT;
      OP_BE:            k = OPK_BLK;
      OP_CE_A, OP_CE_B: k = OPK_CHIP;
      OP_WRSR:          k = OPK_WRSR;
      default:          k = OPK_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/fwp_prot_map.sv
module fwp_prot_map
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  prot_t             prot_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [1:0] quarter;

  assign quarter = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    hit_o = 1'b0;
    case ({prot_i.bp1, prot_i.bp0})
      2'b00: hit_o = 1'b0;
      2'b01: hit_o = prot_i.tb ? (quarter == 2'd0) : (quarter == 2'd3);
      2'b10: hit_o = prot_i.tb ? !quarter[1] : quarter[1];
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fwp_busy_tmr.sv
module fwp_busy_tmr #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/fwp_page_ptr.sv
module fwp_page_ptr #(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  logic [7:0]        data_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [BASE_W-1:0] base_q, base_d;
  logic [PAGE_W-1:0] off_q, off_d;
  logic              ptr_en;
  logic              wr_d;
  logic [ADDR_W-1:0] waddr_d;

  always_comb begin
    ptr_en  = load_i || step_i;
    base_d  = base_q;
    off_d   = off_q;
    wr_d    = 1'b0;
    waddr_d = wr_addr_o;
    if (load_i) begin
      base_d = load_addr_i[ADDR_W-1:PAGE_W];
      off_d  = load_addr_i[PAGE_W-1:0];
    end else if (step_i) begin
      wr_d    = 1'b1;
      waddr_d = {base_q, off_q};
      off_d   = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (ptr_en) begin
      base_q <= base_d;
      off_q  <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_o <= 1'b0;
    else        wr_o <= wr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (step_i && !load_i) begin
      wr_addr_o <= waddr_d;
      wr_data_o <= data_i;
    end
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        nv_prot_i,
  input  logic              wp_n_i,
  input  logic              ev_cmd_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              ev_byte_i,
  input  logic [7:0]        byte_i,
  input  logic              ev_end_i,
  input  logic [TMR_W-1:0]  t_prog_i,
  input  logic [TMR_W-1:0]  t_sect_i,
  input  logic [TMR_W-1:0]  t_blk_i,
  input  logic [TMR_W-1:0]  t_chip_i,
  input  logic [TMR_W-1:0]  t_wrsr_i,
  output logic [7:0]        status_o,
  output logic              acc_o,
  output logic              rej_o,
  output logic [2:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              prog_wr_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o
);
  localparam logic [ADDR_W-1:0] SECT_MASK = {{(ADDR_W-SECT_W){1'b1}}, {SECT_W{1'b0}}};
  localparam logic [ADDR_W-1:0] BLK_MASK  = {{(ADDR_W-BLK_W){1'b1}}, {BLK_W{1'b0}}};
  localparam int NPROT = 2;

  // state registers
  logic              wel_q, wel_d;
  prot_t             prot_q, prot_d;
  logic              act_q, act_d;
  logic [7:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pok_q, pok_d;
  logic              got_q, got_d;
  prot_t             wv_q, wv_d;
  logic              acc_q, acc_d;
  logic              rej_q, rej_d;
  op_kind_t          kind_q, kind_d;
  logic [ADDR_W-1:0] oaddr_q, oaddr_d;

  // combinational helpers
  logic              busy;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              ptr_load;
  logic              ptr_step;
  op_kind_t          cls;
  logic              ok;
  logic [ADDR_W-1:0] prot_addr [NPROT];
  logic [NPROT-1:0]  prot_hit;
  logic              hit_new;
  logic              hit_cur;
  logic              ctx_en;

  assign prot_addr[0] = cmd_addr_i;
  assign prot_addr[1] = addr_q;

  for (genvar g = 0; g < NPROT; g++) begin : g_prot
    fwp_prot_map #(.ADDR_W(ADDR_W)) u_map (
      .prot_i (prot_q),
      .addr_i (prot_addr[g]),
      .hit_o  (prot_hit[g])
    );
  end

  assign hit_new = prot_hit[0];
  assign hit_cur = prot_hit[1];

  fwp_busy_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .busy_o     (busy)
  );

  fwp_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ptr_load),
    .load_addr_i (cmd_addr_i),
    .step_i      (ptr_step),
    .data_i      (byte_i),
    .wr_o        (prog_wr_o),
    .wr_addr_o   (prog_addr_o),
    .wr_data_o   (prog_data_o)
  );

  // next-state logic
  always_comb begin
    wel_d    = wel_q;
    prot_d   = prot_q;
    act_d    = act_q;
    op_d     = op_q;
    addr_d   = addr_q;
    pok_d    = pok_q;
    got_d    = got_q;
    wv_d     = wv_q;
    acc_d    = 1'b0;
    rej_d    = 1'b0;
    kind_d   = kind_q;
    oaddr_d  = oaddr_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    cls      = op_class(op_q);
    ok       = 1'b0;

    if (ev_cmd_i && !busy) begin
      act_d    = 1'b1;
      op_d     = cmd_op_i;
      addr_d   = cmd_addr_i;
      got_d    = 1'b0;
      pok_d    = (cmd_op_i == OP_PROG) && wel_q && !hit_new;
      ptr_load = 1'b1;
    end else if (ev_byte_i && act_q) begin
      if (op_q == OP_PROG && pok_q) ptr_step = 1'b1;
      if (op_q == OP_WRSR && !got_q) begin
        got_d = 1'b1;
        wv_d  = '{bpl: byte_i[7], tb: byte_i[5], bp1: byte_i[3], bp0: byte_i[2]};
      end
    end else if (ev_end_i && act_q) begin
      act_d = 1'b0;
      if (op_q == OP_WREN) begin
        wel_d = 1'b1;
      end else if (op_q == OP_WRDI) begin
        wel_d = 1'b0;
      end else if (cls != OPK_NONE && wel_q && (cls != OPK_WRSR || got_q)) begin
        wel_d  = 1'b0;
        kind_d = cls;
        case (cls)
          OPK_PROG: begin
            ok      = pok_q;
            oaddr_d = addr_q;
            tmr_val = t_prog_i;
          end
          OPK_SECT: begin
            ok      = !hit_cur;
            oaddr_d = addr_q & SECT_MASK;
            tmr_val = t_sect_i;
          end
          OPK_BLK: begin
            ok      = !hit_cur;
            oaddr_d = addr_q & BLK_MASK;
            tmr_val = t_blk_i;
          end
          OPK_CHIP: begin
            ok      = !(prot_q.bp0 || prot_q.bp1 || prot_q.tb);
            oaddr_d = '0;
            tmr_val = t_chip_i;
          end
          default: begin
            ok      = wp_n_i || !prot_q.bpl;
            oaddr_d = '0;
            tmr_val = t_wrsr_i;
            if (ok) prot_d = wv_q;
          end
        endcase
        acc_d    = ok;
        rej_d    = !ok;
        tmr_load = ok;
      end
    end
  end

  assign ctx_en = ev_cmd_i || ev_byte_i || ev_end_i;

  // status and command context registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      prot_q <= nv_prot_i;
      act_q  <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      pok_q  <= 1'b0;
      got_q  <= 1'b0;
      wv_q   <= '0;
    end else if (ctx_en) begin
      wel_q  <= wel_d;
      prot_q <= prot_d;
      act_q  <= act_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      pok_q  <= pok_d;
      got_q  <= got_d;
      wv_q   <= wv_d;
    end
  end

  // outcome strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
      kind_q  <= OPK_NONE;
      oaddr_q <= '0;
    end else begin
      acc_q   <= acc_d;
      rej_q   <= rej_d;
      kind_q  <= kind_d;
      oaddr_q <= oaddr_d;
    end
  end

  assign status_o  = {prot_q.bpl, 1'b0, prot_q.tb, 1'b0, prot_q.bp1, prot_q.bp0, wel_q, busy};
  assign acc_o     = acc_q;
  assign rej_o     = rej_q;
  assign op_kind_o = kind_q;
  assign op_addr_o = oaddr_q;
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status_o,
  input logic       acc_o,
  input logic       rej_o,
  input logic [2:0] op_kind_o
);
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_o && rej_o));

  assert_wel_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o || rej_o) |-> !status_o[1]);

  assert_need_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o || rej_o) |-> $past(status_o[1]));

  assert_idle_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> !$past(status_o[0]));

  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_o && op_kind_o == 3'd5) |-> $stable({status_o[7], status_o[5], status_o[3:2]}));

  assert_chip_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o && op_kind_o == 3'd4) |-> ($past({status_o[5], status_o[3:2]}) == 3'b000));
endmodule

bind flash_wp_ctrl fwp_checker u_fwp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .status_o  (status_o),
  .acc_o     (acc_o),
  .rej_o     (rej_o),
  .op_kind_o (op_kind_o)
);

// File: tb/flash_wp_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  nv_prot = 4'hF;
  logic        wp_n = 1'b1;
  logic        ev_cmd = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [17:0] cmd_addr = '0;
  logic        ev_byte = 1'b0;
  logic [7:0]  byte_v = 8'h00;
  logic        ev_end = 1'b0;
  logic [15:0] t_prog = 16'd5, t_sect = 16'd7, t_blk = 16'd9, t_chip = 16'd12, t_wrsr = 16'd3;
  logic [7:0]  status;
  logic        acc, rej, pw;
  logic [2:0]  kind;
  logic [17:0] oaddr, paddr;
  logic [7:0]  pdata;

  int total = 0, bad = 0, cyc = 0;
  int acc_cnt = 0, rej_cnt = 0, pw_cnt = 0;
  int last_acc_addr = 0, last_pw_addr = 0, last_pw_data = 0;

  always #2.5 clk = ~clk;

  flash_wp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nv_prot_i(nv_prot), .wp_n_i(wp_n),
    .ev_cmd_i(ev_cmd), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .ev_byte_i(ev_byte), .byte_i(byte_v), .ev_end_i(ev_end),
    .t_prog_i(t_prog), .t_sect_i(t_sect), .t_blk_i(t_blk), .t_chip_i(t_chip), .t_wrsr_i(t_wrsr),
    .status_o(status), .acc_o(acc), .rej_o(rej), .op_kind_o(kind), .op_addr_o(oaddr),
    .prog_wr_o(pw), .prog_addr_o(paddr), .prog_data_o(pdata)
  );

  // ---------------- behavioural reference model ----------------
  int m_wel, m_bp0, m_bp1, m_tb, m_bpl, m_cnt;
  int m_active, m_op, m_addr, m_pok, m_got, m_data, m_off;
  int m_acc, m_rej, m_kind, m_oaddr, m_pwv, m_pwa, m_pwd;

  function automatic int in_prot(int a);
    case (m_bp1 * 2 + m_bp0)
      0: return 0;
      1: return m_tb ? (a < 'h10000) : (a >= 'h30000);
      2: return m_tb ? (a < 'h20000) : (a >= 'h20000);
      default: return 1;
    endcase
  endfunction

  function automatic int m_status();
    return m_bpl * 128 + m_tb * 32 + m_bp1 * 8 + m_bp0 * 4 + m_wel * 2 + (m_cnt != 0 ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wel = 0; m_cnt = 0; m_active = 0; m_acc = 0; m_rej = 0; m_pwv = 0;
      m_bp0 = nv_prot[0]; m_bp1 = nv_prot[1]; m_tb = nv_prot[2]; m_bpl = nv_prot[3];
    end else begin
      int busy_now, cls, ok, tv;
      busy_now = (m_cnt != 0);
      m_acc = 0; m_rej = 0; m_pwv = 0;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (ev_cmd && !busy_now) begin
        m_active = 1; m_op = cmd_op; m_addr = cmd_addr; m_got = 0;
        m_off = m_addr % 256;
        m_pok = (cmd_op == 8'h02) && m_wel && !in_prot(m_addr);
      end else if (ev_byte && m_active) begin
        if (m_op == 2 && m_pok) begin
          m_pwv = 1; m_pwa = (m_addr / 256) * 256 + m_off; m_pwd = byte_v;
          m_off = (m_off + 1) % 256;
        end
        if (m_op == 1 && !m_got) begin m_got = 1; m_data = byte_v; end
      end else if (ev_end && m_active) begin
        m_active = 0;
        case (m_op)
          'h02: cls = 1;
          'h20, 'hD7: cls = 2;
          'hD8: cls = 3;
          'h60, 'hC7: cls = 4;
          'h01: cls = 5;
          default: cls = 0;
        endcase
        if (m_op == 'h06) m_wel = 1;
        else if (m_op == 'h04) m_wel = 0;
        else if (cls != 0 && m_wel && (cls != 5 || m_got)) begin
          m_wel = 0; m_kind = cls; ok = 0; tv = 0;
          case (cls)
            1: begin ok = m_pok; m_oaddr = m_addr; tv = t_prog; end
            2: begin ok = !in_prot(m_addr); m_oaddr = (m_addr / 4096) * 4096; tv = t_sect; end
            3: begin ok = !in_prot(m_addr); m_oaddr = (m_addr / 65536) * 65536; tv = t_blk; end
            4: begin ok = (m_bp0 == 0 && m_bp1 == 0 && m_tb == 0); m_oaddr = 0; tv = t_chip; end
            default: begin
              ok = wp_n || !m_bpl; m_oaddr = 0; tv = t_wrsr;
              if (ok) begin
                m_bpl = (m_data >> 7) & 1; m_tb = (m_data >> 5) & 1;
                m_bp1 = (m_data >> 3) & 1; m_bp0 = (m_data >> 2) & 1;
              end
            end
          endcase
          m_acc = ok; m_rej = !ok;
          if (ok) m_cnt = tv;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 status vs model", status, m_status());
      chk("R7 accept strobe vs model", acc, m_acc);
      chk("R7 reject strobe vs model", rej, m_rej);
      if (m_acc || m_rej) begin
        chk("R8 kind vs model", kind, m_kind);
        chk("R8 address vs model", oaddr, m_oaddr);
      end
      chk("R12 byte strobe vs model", pw, m_pwv);
      if (m_pwv) begin
        chk("R12 byte address vs model", paddr, m_pwa);
        chk("R12 byte data vs model", pdata, m_pwd);
      end
      if (acc) begin acc_cnt++; last_acc_addr = oaddr; end
      if (rej) rej_cnt++;
      if (pw) begin pw_cnt++; last_pw_addr = paddr; last_pw_data = pdata; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [7:0] op, input int addr);
    ev_cmd = 1'b1; cmd_op = op; cmd_addr = addr[17:0];
    @(negedge clk);
    ev_cmd = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b);
    ev_byte = 1'b1; byte_v = b;
    @(negedge clk);
    ev_byte = 1'b0;
  endtask

  task automatic do_end();
    ev_end = 1'b1;
    @(negedge clk);
    ev_end = 1'b0;
  endtask

  task automatic simple(input logic [7:0] op, input int addr);
    do_cmd(op, addr);
    do_end();
  endtask

  task automatic wait_ready();
    while (status[0]) @(negedge clk);
  endtask

  task automatic wrsr(input logic [7:0] d);
    simple(8'h06, 0);
    do_cmd(8'h01, 0);
    do_byte(d);
    do_end();
    wait_ready();
  endtask

  initial begin
    int a0, r0, p0, n;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset status from init value", status, 8'hAC);

    simple(8'h06, 0);
    chk("R2 set latch", status, 8'hAE);
    simple(8'h04, 0);
    chk("R2 clear latch", status, 8'hAC);

    a0 = acc_cnt; r0 = rej_cnt; p0 = pw_cnt;
    do_cmd(8'h02, 'h100); do_byte(8'h55); do_end();
    simple(8'hC7, 0);
    tick(2);
    chk("R3 no strobe without latch", acc_cnt + rej_cnt, a0 + r0);
    chk("R3 no byte without latch", pw_cnt, p0);
    chk("R3 status unchanged", status, 8'hAC);

    simple(8'h06, 0);
    do_cmd(8'h01, 0); do_byte(8'h00); do_end();
    chk("R5 lock ignored with pin high, busy set", status, 8'h01);
    wait_ready();
    chk("R4 latch cleared after status write", status, 8'h00);

    wrsr(8'h04);
    chk("R5 status write top quarter", status, 8'h04);
    r0 = rej_cnt;
    simple(8'h06, 0); simple(8'h20, 'h31000); tick(1);
    chk("R7 sector erase in top quarter rejected", rej_cnt, r0 + 1);
    chk("R4 latch cleared after reject", status, 8'h04);

    simple(8'h06, 0); simple(8'hD7, 'h2F123); tick(1);
    chk("R8 sector address aligned", last_acc_addr, 'h2F000);
    wait_ready();
    simple(8'h06, 0); simple(8'hD8, 'h2ABCD); tick(1);
    chk("R8 block address aligned", last_acc_addr, 'h20000);
    wait_ready();
    r0 = rej_cnt;
    simple(8'h06, 0); simple(8'hD8, 'h3FFFF); tick(1);
    chk("R6 block in top quarter rejected", rej_cnt, r0 + 1);

    wrsr(8'h28);
    chk("R6 bottom half selected", status, 8'h28);
    r0 = rej_cnt;
    simple(8'h06, 0); do_cmd(8'h02, 'h1FFFE); do_byte(8'h11); do_end(); tick(1);
    chk("R6 program in bottom half rejected", rej_cnt, r0 + 1);
    p0 = pw_cnt;
    simple(8'h06, 0);
    do_cmd(8'h02, 'h200FE);
    do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3); do_byte(8'hA4);
    do_end(); tick(1);
    chk("R12 four bytes forwarded", pw_cnt, p0 + 4);
    chk("R12 page wrap address", last_pw_addr, 'h20001);
    chk("R12 last data", last_pw_data, 8'hA4);
    wait_ready();

    r0 = rej_cnt;
    simple(8'h06, 0); simple(8'h60, 0); tick(1);
    chk("R9 chip erase rejected with protection", rej_cnt, r0 + 1);
    wrsr(8'h20);
    r0 = rej_cnt;
    simple(8'h06, 0); simple(8'h60, 0); tick(1);
    chk("R9 chip erase rejected with TB set", rej_cnt, r0 + 1);

    wrsr(8'h00);
    a0 = acc_cnt;
    simple(8'h06, 0); simple(8'hC7, 0);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
    chk("R10 busy length for chip erase", n, 12);
    chk("R9 chip erase accepted", acc_cnt, a0 + 1);

    simple(8'h06, 0); simple(8'hC7, 0);
    simple(8'h06, 0);
    wait_ready();
    chk("R11 latch command ignored while busy", status, 8'h00);

    wrsr(8'h8C);
    chk("R5 lock set", status, 8'h8C);
    wp_n = 1'b0;
    r0 = rej_cnt;
    wrsr(8'h00); tick(1);
    chk("R5 locked status write refused", rej_cnt, r0 + 1);
    chk("R5 locked bits kept", status, 8'h8C);
    wp_n = 1'b1;
    wrsr(8'h00);
    chk("R5 unlocked by pin", status, 8'h00);

    wrsr(8'h0C);
    r0 = rej_cnt;
    simple(8'h06, 0); do_cmd(8'h02, 'h0); do_byte(8'h01); do_end(); tick(1);
    chk("R6 full protection rejects program", rej_cnt, r0 + 1);
    wrsr(8'h08);
    a0 = acc_cnt; r0 = rej_cnt;
    simple(8'h06, 0); do_cmd(8'h02, 'h1FFFF); do_byte(8'h02); do_end(); wait_ready();
    simple(8'h06, 0); do_cmd(8'h02, 'h20000); do_byte(8'h03); do_end(); tick(1);
    chk("R6 below top half accepted", acc_cnt, a0 + 1);
    chk("R6 top half start rejected", rej_cnt, r0 + 1);

    t_wrsr = 16'd0;
    simple(8'h06, 0);
    do_cmd(8'h01, 0); do_byte(8'h04); do_end();
    chk("R10 zero count leaves busy clear", status, 8'h04);
    tick(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule